// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a flash memory interface and decides when an embedded program or erase operation inside the flash has finished. After the command sequence has been issued elsewhere, the host pulses `start` with the operation kind, the byte that was written and an address to poll. For a program, that address is the location being written. For an erase, it is any address inside an unprotected sector that is being erased. The block then reads that address over and over through a simple request/acknowledge read port until the status byte says the operation is over.

Each returned byte is judged on two bits. Bit 7 is the completion bit and bit 5 is the time-limit failure bit. When bit 7 equals the target, the operation has completed. The target is bit 7 of the written byte for a program and 1 for an erase. When bit 7 differs and bit 5 is clear, the block polls again. When bit 5 is set, the block makes exactly one further read and tests bit 7 once more, because bit 7 can change in the same instant as bit 5. A match on that read is reported as a pass. A mismatch is reported as an exceeded-time error.

A parameterised cap on the number of polls acts as a host-side watchdog and has its own result code. After either error, `reset_needed` tells the host that the flash must get a reset command before it will return array data again.

Top module: `poll_done_checker`

## Requirements
- R1: After reset, `rd_req`, `done`, `busy` and `reset_needed` are all 0.
- R2: A `start` seen while idle captures `poll_addr`. From the next cycle `rd_req` is 1, and `rd_addr` equals the captured address. Both stay unchanged until a cycle in which `rd_ack` is 1, and only that cycle consumes the returned `rd_data`.
- R3: The target for bit 7 is `exp_data[7]` when `op_erase` is 0 (program) and 1 when `op_erase` is 1 (erase). A read whose `rd_data[7]` equals the target ends the operation with `result` = 2'b00 (pass).
- R4: A read whose `rd_data[7]` differs from the target and whose `rd_data[5]` is 0 is followed by another read of the same address, with `rd_req` staying 1.
- R5: A read with a bit 7 mismatch and `rd_data[5]` = 1 is followed by exactly one more read. If bit 7 of that read matches, `result` is 2'b00. Otherwise `result` is 2'b01 (exceeded-time error).
- R6: `reset_needed` becomes 1 with any completion whose `result` is not 2'b00. It stays 1 until the next accepted `start`, and it is 0 with every pass.
- R7: When MAX_POLLS reads in a row end with a bit 7 mismatch and bit 5 clear, the operation ends with `result` = 2'b10 (watchdog timeout).
- R8: When the read that reaches the MAX_POLLS limit shows bit 5 set, the recheck read of R5 still happens, and its outcome decides the result instead of the watchdog.
- R9: A `start` while `busy` is 1 is ignored. The address and target of the running operation are kept.
- R10: `done` is 1 for exactly one cycle, namely the cycle after the deciding acknowledge. In that cycle `busy` and `rd_req` are 0, and `result` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin polling (single-cycle pulse) |
| op_erase | input | 1 | 1 = erase, 0 = program |
| exp_data | input | DW | Byte that was programmed |
| poll_addr | input | AW | Address to poll |
| rd_req | output | 1 | Read request to the flash read port |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completed; `rd_data` valid |
| rd_data | input | DW | Byte returned by the read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Single-cycle completion strobe |
| result | output | 2 | 00 pass, 01 exceeded-time error, 10 watchdog timeout |
| reset_needed | output | 1 | Flash needs a reset command |

## Verification
Two functions can act on the same acknowledge: the poll-count watchdog and the bit 5 recheck path, when the read that uses up the last allowed poll also carries bit 5. The bench provokes this by returning mismatching bytes with bit 5 clear up to one short of the limit, then a byte with bit 5 set on the final allowed poll. It then checks that a fifth read is requested and that the result comes from that read, pass in one run and exceeded-time error in another, and never the watchdog code. A second collision, a `start` arriving while a read is pending, is judged by checking the address of every later read and the completion outcome, which depends on the original target.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int DONE_BIT = 7;
    localparam int FAIL_BIT = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_POLL    = 2'b01,
        ST_RECHECK = 2'b10
    } poll_state_e;

    typedef enum logic [1:0] {
        RES_PASS     = 2'b00,
        RES_EXCEEDED = 2'b01,
        RES_WATCHDOG = 2'b10
    } poll_result_e;

    typedef struct packed {
        logic bit_ok;
        logic fail_seen;
    } poll_eval_t;

    function automatic logic target_of(input logic is_erase, input logic exp_msb);
        return is_erase ? 1'b1 : exp_msb;
    endfunction

endpackage

// File: rtl/poll_target.sv
module poll_target #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          op_erase,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic          target_q
);
    import poll_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            target_q <= 1'b0;
        end else if (load) begin
            addr_q   <= addr_in;
            target_q <= target_of(op_erase, exp_data[DONE_BIT]);
        end
    end
endmodule

// File: rtl/poll_eval.sv
module poll_eval #(
    parameter int DW = 8
) (
    input  logic            target,
    input  logic [DW-1:0]   rd_data,
    output poll_pkg::poll_eval_t ev
);
    import poll_pkg::*;

    always_comb begin
        ev.bit_ok    = (rd_data[DONE_BIT] == target);
        ev.fail_seen = rd_data[FAIL_BIT];
    end
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign last = (cnt == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 rd_ack,
    input  poll_pkg::poll_eval_t ev,
    input  logic                 wd_last,
    output logic                 load,
    output logic                 wd_inc,
    output logic                 rd_req,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           result,
    output logic                 reset_needed
);
    import poll_pkg::*;

    poll_state_e  state, state_nx;
    logic         finish;
    poll_result_e fin_res;

    always_comb begin
        load     = (state == ST_IDLE) && start;
        rd_req   = (state != ST_IDLE);
        busy     = (state != ST_IDLE);
        wd_inc   = (state == ST_POLL) && rd_ack && !ev.bit_ok && !ev.fail_seen;
        finish   = 1'b0;
        fin_res  = RES_PASS;
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_POLL;
            ST_POLL: if (rd_ack) begin
                if (ev.bit_ok) begin
                    finish = 1'b1;
                end else if (ev.fail_seen) begin
                    state_nx = ST_RECHECK;
                end else if (wd_last) begin
                    finish  = 1'b1;
                    fin_res = RES_WATCHDOG;
                end
            end
            ST_RECHECK: if (rd_ack) begin
                finish  = 1'b1;
                fin_res = ev.bit_ok ? RES_PASS : RES_EXCEEDED;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (finish) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            done         <= 1'b0;
            result       <= RES_PASS;
            reset_needed <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= finish;
            if (load) reset_needed <= 1'b0;
            if (finish) begin
                result       <= fin_res;
                reset_needed <= (fin_res != RES_PASS);
            end
        end
    end
endmodule

// File: rtl/poll_done_checker.sv
module poll_done_checker #(
    parameter int AW        = 20,
    parameter int DW        = 8,
    parameter int MAX_POLLS = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_erase,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] poll_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          reset_needed
);
    import poll_pkg::*;

    logic       load, wd_inc, wd_last, target;
    poll_eval_t ev;

    poll_target #(.AW(AW), .DW(DW)) u_target (
        .clk(clk), .rst(rst), .load(load), .op_erase(op_erase),
        .exp_data(exp_data), .addr_in(poll_addr),
        .addr_q(rd_addr), .target_q(target)
    );

    poll_eval #(.DW(DW)) u_eval (
        .target(target), .rd_data(rd_data), .ev(ev)
    );

    poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wd (
        .clk(clk), .rst(rst), .clr(load), .inc(wd_inc), .last(wd_last)
    );

    poll_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .rd_ack(rd_ack), .ev(ev),
        .wd_last(wd_last), .load(load), .wd_inc(wd_inc), .rd_req(rd_req),
        .busy(busy), .done(done), .result(result), .reset_needed(reset_needed)
    );
endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          busy,
    input logic          done,
    input logic [1:0]    result,
    input logic          reset_needed
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    assert_start_req_R2: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> rd_req);

    assert_err_flag_R6: assert property (@(posedge clk) disable iff (rst)
        done && result != 2'b00 |-> reset_needed);

    assert_pass_flag_R6: assert property (@(posedge clk) disable iff (rst)
        done && result == 2'b00 |-> !reset_needed);

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> result != 2'b11);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        busy && start && !rd_ack |=> busy && $stable(rd_addr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !rd_req);
endmodule

bind poll_done_checker poll_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_addr(rd_addr), .busy(busy), .done(done), .result(result),
    .reset_needed(reset_needed)
);

// File: tb/sim_poll_done_checker.sv
module sim_poll_done_checker;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int MAXP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic [DW-1:0] exp_data = '0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done, reset_needed;
    logic [1:0]    result;

    int errors = 0;
    int checks = 0;
    int ack_cnt = 0;
    bit finished = 0;
    logic [7:0] scr [0:7];
    logic [7:0] sb_q [$];

    always #2.5 clk = ~clk;

    poll_done_checker #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
        .exp_data(exp_data), .poll_addr(poll_addr), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
        .done(done), .result(result), .reset_needed(reset_needed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected {result, reads} on each done strobe.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                chk(result == e[7:6], "R3/R5/R7/R8 result", result, e[7:6]);
                chk(ack_cnt == int'(e[5:0]), "R4/R5 read count", ack_cnt, e[5:0]);
                chk(reset_needed == (e[7:6] != 2'b00), "R6 reset_needed",
                    reset_needed, (e[7:6] != 2'b00));
                chk(!busy && !rd_req, "R10 idle at done", {busy, rd_req}, 0);
            end
        end
    end

    // Driver: runs one operation, answering reads with scr[0..n-1].
    task automatic run_op(input logic erase, input logic [7:0] exp,
                          input logic [AW-1:0] addr, input int n,
                          input logic [1:0] res, input bit inject);
        sb_q.push_back({res, 6'(n)});
        ack_cnt = 0;
        op_erase = erase; exp_data = exp; poll_addr = addr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(reset_needed == 1'b0, "R6 cleared by start", reset_needed, 0);
        for (int k = 0; k < n; k++) begin
            int w = 0;
            while (!rd_req && w < 20) begin @(negedge clk); w++; end
            if (inject && k == 1) begin
                start = 1'b1; op_erase = ~erase; exp_data = ~exp; poll_addr = ~addr;
                @(negedge clk);
                start = 1'b0;
                chk(busy == 1'b1, "R9 still busy", busy, 1);
            end
            chk(rd_req == 1'b1, "R2/R4 read requested", rd_req, 1);
            chk(rd_addr == addr, "R2/R9 read address", rd_addr, addr);
            rd_ack = 1'b1; rd_data = scr[k]; ack_cnt++;
            @(negedge clk);
            rd_ack = 1'b0;
        end
        chk(rd_req == 1'b0, "R10 no further read", rd_req, 0);
        chk(done == 1'b1, "R10 done strobe", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({rd_req, done, busy, reset_needed} == 4'b0, "R1 reset state",
            {rd_req, done, busy, reset_needed}, 0);

        // R3/R4: program, target bit7=0
        scr[0] = 8'h80; scr[1] = 8'h5A;
        run_op(1'b0, 8'h5A, 16'h1234, 2, 2'b00, 0);
        // R3/R4: program, target bit7=1
        scr[0] = 8'h43; scr[1] = 8'h00; scr[2] = 8'hC3;
        run_op(1'b0, 8'hC3, 16'h0042, 3, 2'b00, 0);
        // R3: erase target is 1 regardless of exp_data
        scr[0] = 8'h00; scr[1] = 8'hFF;
        run_op(1'b1, 8'h00, 16'h8000, 2, 2'b00, 0);
        // R5: bit5 then recheck match
        scr[0] = 8'h20; scr[1] = 8'h80;
        run_op(1'b1, 8'h00, 16'h8001, 2, 2'b00, 0);
        // R5/R6: bit5 then recheck mismatch -> exceeded
        scr[0] = 8'hA0; scr[1] = 8'hA0;
        run_op(1'b0, 8'h11, 16'h0300, 2, 2'b01, 0);
        // R9/R6: start while busy ignored; original program target bit7=0
        scr[0] = 8'h80; scr[1] = 8'h80; scr[2] = 8'h00;
        run_op(1'b0, 8'h11, 16'h0555, 3, 2'b00, 1);
        // R7: watchdog after MAXP plain mismatches
        scr[0] = 8'h00; scr[1] = 8'h00; scr[2] = 8'h00; scr[3] = 8'h00;
        run_op(1'b1, 8'h00, 16'h9000, 4, 2'b10, 0);
        chk(reset_needed == 1'b1, "R6 flag held after error", reset_needed, 1);
        // R8: bit5 on last allowed poll, recheck matches
        scr[0] = 8'h00; scr[1] = 8'h00; scr[2] = 8'h00; scr[3] = 8'h20; scr[4] = 8'hFF;
        run_op(1'b1, 8'h00, 16'h9001, 5, 2'b00, 0);
        // R8: bit5 on last allowed poll, recheck mismatches
        scr[4] = 8'h00;
        run_op(1'b1, 8'h00, 16'h9002, 5, 2'b01, 0);

        chk(sb_q.size() == 0, "R10 all completions seen", sb_q.size(), 0);
        finished = 1;
    end

    initial begin
        int n = 0;
        while (!finished && n < 20000) begin @(posedge clk); n++; end
        if (!finished) chk(1'b0, "watchdog expired", n, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule